// File: doc/BRIEF.md
# SCSI Initiator Selection Controller

This block carries out the initiator side of a selection without arbitration on a narrow parallel SCSI bus. A one-cycle `start` with a 3-bit `target_id` begins an attempt. The block first confirms over several consecutive clock cycles that the bus is free. It then drives an ID byte on the data bus and asserts SEL. After that it waits for the target to answer with BSY, sampling BSY only once per poll interval. The poll interval is built by counting an external microsecond tick. The attempt ends with a one-cycle `done` and a `fail` bit that is held until the next accepted start. A successful attempt sets the `selected` flag. A sequencer clears this flag with `clr_sel` after message-in or after a bus reset. If the flag is already set when a start arrives, the block reports success straight away and leaves the bus alone.

The states are ST_IDLE, ST_CHECK, ST_DRIVE and ST_REPORT, with these transitions:
- ST_IDLE to ST_CHECK on a start while not selected.
- ST_IDLE to ST_REPORT on a start while selected.
- ST_CHECK to ST_REPORT when a busy sample is seen.
- ST_CHECK to ST_DRIVE after IDLE_SAMPLES free samples.
- ST_DRIVE to ST_REPORT at a poll instant where BSY is seen (success), or at the last poll instant without BSY (failure).
- ST_REPORT to ST_IDLE always.

Top module: `scsi_sel_ctrl`

## Requirements
- R1: After reset, all of the following are 0: `done`, `fail`, `selected`, `sel_out`, `data_oe` and `data_out`.
- R2: A start while `selected` is 1 gives `done`=1 with `fail`=0 in the next cycle. The bus outputs stay low, whatever BSY and SEL show.
- R3: A start while not selected samples `bsy_in` and `sel_in` at each of the next IDLE_SAMPLES clock edges (default 3). A sample with either line at 1 ends the attempt: `done`=1 and `fail`=1 in the following cycle. In that case `sel_out` is never driven. No drive begins before all the samples are taken.
- R4: After IDLE_SAMPLES free samples, `sel_out` and `data_oe` rise together. While they are high, `data_out` equals 8'h80 | (1 << `target_id`). Bit 7 is the initiator's own ID, so target 0 gives 8'h81 and target 7 gives 8'h80.
- R5: While driving, BSY is sampled only at poll instants. A poll instant is every TICKS_PER_POLL-th `us_tick` counted since drive began. BSY at a poll instant gives success: `done`=1, `fail`=0 and `selected`=1. BSY between poll instants has no effect.
- R6: If BSY is absent at MAX_POLLS poll instants, the attempt fails at the last of them: `done`=1, `fail`=1, and `selected` is unchanged at 0.
- R7: `done` lasts exactly one cycle. In that same cycle, `sel_out` and `data_oe` are 0 and `data_out` is 0.
- R8: `fail` holds its value after `done` until the next accepted start, which clears it.
- R9: `clr_sel` clears `selected` in the next cycle, and takes priority over setting it. A `start` while an attempt is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a selection attempt (honoured only when idle) |
| target_id | input | 3 | Target ID, captured at start |
| clr_sel | input | 1 | Clear the selected flag |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bsy_in | input | 1 | BSY line as seen on the bus |
| sel_in | input | 1 | SEL line as seen on the bus |
| data_out | output | 8 | ID byte for the data bus |
| data_oe | output | 1 | Data bus drive enable |
| sel_out | output | 1 | Assert SEL |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last attempt (1 = failed) |
| selected | output | 1 | Target currently selected |

## Verification
The bench builds the block with TICKS_PER_POLL=4 and MAX_POLLS=5, so the full timeout is 20 ticks. At that size the bench can reach the exhausted-poll failure and can place BSY just before a poll instant. IDLE_SAMPLES keeps its default of 3 and the ID width keeps its default of 3. This lets the bench put a busy line on the first or the last free-bus sample, and cover both extremes of the ID byte (targets 0 and 7).

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DRIVE,
        ST_REPORT
    } sel_state_e;
endpackage

// File: rtl/sel_interval.sv
module sel_interval #(
    parameter int TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic due
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == CW'(TICKS - 1));
    assign due    = en && tick && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= CW'(TICKS - 1)));  // R5
endmodule

// File: rtl/sel_poll_ctr.sv
module sel_poll_ctr #(
    parameter int MAX = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    output logic last
);
    localparam int PW = (MAX > 1) ? $clog2(MAX) : 1;

    logic [PW-1:0] cnt;

    assign last = (cnt == PW'(MAX - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (step && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= PW'(MAX - 1)));  // R6
endmodule

// File: rtl/scsi_sel_ctrl.sv
module scsi_sel_ctrl
    import scsi_sel_pkg::*;
#(
    parameter int ID_W           = 3,
    parameter int INIT_BIT       = 7,
    parameter int IDLE_SAMPLES   = 3,
    parameter int TICKS_PER_POLL = 100,
    parameter int MAX_POLLS      = 2500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ID_W-1:0]      target_id,
    input  logic                 clr_sel,
    input  logic                 us_tick,
    input  logic                 bsy_in,
    input  logic                 sel_in,
    output logic [(1<<ID_W)-1:0] data_out,
    output logic                 data_oe,
    output logic                 sel_out,
    output logic                 done,
    output logic                 fail,
    output logic                 selected
);
    localparam int DATA_W = 1 << ID_W;
    localparam int CKW    = (IDLE_SAMPLES > 1) ? $clog2(IDLE_SAMPLES) : 1;

    sel_state_e      state, state_nx;
    logic [CKW-1:0]  chk_cnt;
    logic [ID_W-1:0] tgt_q;
    logic            fail_q, selected_q;
    logic            in_drive, poll_due, poll_last;
    logic            go_ok, go_bad, accept;
    logic [DATA_W-1:0] id_byte;

    assign in_drive = (state == ST_DRIVE);
    assign accept   = (state == ST_IDLE) && start;

    // ID byte: initiator bit merged with one-hot target bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_idbit
        assign id_byte[i] = (tgt_q == ID_W'(i)) || (i == INIT_BIT);
    end

    sel_interval #(.TICKS(TICKS_PER_POLL)) u_interval (
        .clk(clk), .rst_n(rst_n), .en(in_drive), .tick(us_tick), .due(poll_due)
    );

    sel_poll_ctr #(.MAX(MAX_POLLS)) u_polls (
        .clk(clk), .rst_n(rst_n), .en(in_drive), .step(poll_due), .last(poll_last)
    );

    // next state
    always_comb begin
        state_nx = state;
        go_ok    = 1'b0;
        go_bad   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (selected_q) begin
                        state_nx = ST_REPORT;
                        go_ok    = 1'b1;
                    end else begin
                        state_nx = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (bsy_in || sel_in) begin
                    state_nx = ST_REPORT;
                    go_bad   = 1'b1;
                end else if (chk_cnt == CKW'(IDLE_SAMPLES - 1)) begin
                    state_nx = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                if (poll_due) begin
                    if (bsy_in) begin
                        state_nx = ST_REPORT;
                        go_ok    = 1'b1;
                    end else if (poll_last) begin
                        state_nx = ST_REPORT;
                        go_bad   = 1'b1;
                    end
                end
            end
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register and held status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            chk_cnt    <= '0;
            tgt_q      <= '0;
            fail_q     <= 1'b0;
            selected_q <= 1'b0;
        end else begin
            state   <= state_nx;
            chk_cnt <= (state == ST_CHECK) ? chk_cnt + 1'b1 : '0;
            if (accept) begin
                tgt_q  <= target_id;
                fail_q <= 1'b0;
            end else if (go_bad) begin
                fail_q <= 1'b1;
            end
            if (clr_sel)
                selected_q <= 1'b0;
            else if (go_ok)
                selected_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sel_out  = in_drive;
        data_oe  = in_drive;
        data_out = in_drive ? id_byte : '0;
        done     = (state == ST_REPORT);
        fail     = fail_q;
        selected = selected_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sel_out && !data_oe && data_out == '0));  // R7
    AST_ID_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out[INIT_BIT] && $countones(data_out) <= 2));  // R4
    AST_FREE_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_out) |-> $past(!bsy_in && !sel_in));  // R3
    AST_SET_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> (done && !fail));  // R5
    AST_FAIL_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> !selected);  // R6
endmodule

// File: tb/tb_scsi_sel_ctrl.sv
module tb_scsi_sel_ctrl;
    localparam int TPP = 4;
    localparam int NP  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] target_id = '0;
    logic       clr_sel = 1'b0;
    logic       us_tick = 1'b0;
    logic       bsy_in = 1'b0;
    logic       sel_in = 1'b0;
    logic [7:0] data_out;
    logic       data_oe, sel_out, done, fail, selected;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    scsi_sel_ctrl #(.TICKS_PER_POLL(TPP), .MAX_POLLS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_id(target_id),
        .clr_sel(clr_sel), .us_tick(us_tick), .bsy_in(bsy_in), .sel_in(sel_in),
        .data_out(data_out), .data_oe(data_oe), .sel_out(sel_out),
        .done(done), .fail(fail), .selected(selected)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [2:0] id);
        start = 1'b1; target_id = id;
        cyc();
        start = 1'b0;
    endtask

    task automatic tick();
        us_tick = 1'b1;
        cyc();
        us_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check({done, fail, selected, sel_out, data_oe} == 5'b0 && data_out == 8'h00,
              "R1 reset outputs", {done, fail, selected, sel_out, data_oe}, 0);
    endtask

    task automatic t_busy_first();
        sel_in = 1'b1;
        pulse_start(3'd2);
        cyc();
        check(done && fail && !sel_out, "R3 busy first sample", {done, fail, sel_out}, 3'b110);
        sel_in = 1'b0;
        cyc();
        check(!done, "R7 done one cycle", done, 0);
    endtask

    task automatic t_busy_last();
        pulse_start(3'd2);
        cyc();
        cyc();
        check(!sel_out, "R3 no drive during check", sel_out, 0);
        bsy_in = 1'b1;
        cyc();
        check(done && fail && !sel_out && !data_oe, "R3 busy last sample",
              {done, fail, sel_out, data_oe}, 4'b1100);
        bsy_in = 1'b0;
        cyc();
    endtask

    task automatic t_success(input logic [2:0] id, input logic [7:0] exp_b);
        pulse_start(id);
        cyc();
        cyc();
        check(!sel_out && !data_oe, "R3 drive waits for samples", sel_out, 0);
        cyc();
        check(sel_out && data_oe && data_out == exp_b, "R4 id byte driven", data_out, exp_b);
        bsy_in = 1'b1;
        repeat (TPP - 1) tick();
        check(sel_out && !done, "R5 bsy ignored between polls", {sel_out, done}, 2'b10);
        tick();
        check(done && !fail && selected, "R5 success at poll", {done, fail, selected}, 3'b101);
        check(!sel_out && !data_oe && data_out == 8'h00, "R7 release at done",
              {sel_out, data_oe, data_out}, 0);
        bsy_in = 1'b0;
        cyc();
        check(!done && selected, "R7 done drops", {done, selected}, 2'b01);
    endtask

    task automatic t_already();
        bsy_in = 1'b1;
        pulse_start(3'd5);
        check(done && !fail && !sel_out && !data_oe, "R2 already selected",
              {done, fail, sel_out, data_oe}, 4'b1000);
        bsy_in = 1'b0;
        cyc();
    endtask

    task automatic t_clear();
        clr_sel = 1'b1;
        cyc();
        clr_sel = 1'b0;
        check(!selected, "R9 clr_sel", selected, 0);
    endtask

    task automatic t_timeout();
        pulse_start(3'd0);
        repeat (3) cyc();
        check(sel_out && data_out == 8'h81, "R4 target0 byte", data_out, 8'h81);
        repeat (6) tick();
        pulse_start(3'd6);
        check(sel_out && data_out == 8'h81, "R9 start ignored while busy", data_out, 8'h81);
        repeat (TPP * NP - 7) tick();
        check(sel_out && !done, "R6 still polling", {sel_out, done}, 2'b10);
        tick();
        check(done && fail && !selected, "R6 timeout fail", {done, fail, selected}, 3'b110);
        repeat (4) cyc();
        check(fail && !done, "R8 fail held", {fail, done}, 2'b10);
        pulse_start(3'd1);
        check(!fail, "R8 fail cleared on start", fail, 0);
        repeat (3) cyc();
        bsy_in = 1'b1;
        repeat (TPP) tick();
        check(done && !fail && selected, "R5 success after timeout", {done, fail, selected}, 3'b101);
        bsy_in = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cyc();
        t_reset();
        t_busy_first();
        t_busy_last();
        t_success(3'd3, 8'h88);
        t_already();
        t_clear();
        t_success(3'd7, 8'h80);
        t_clear();
        t_timeout();
        t_clear();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule